// File: doc/BRIEF.md
# Shadow Register Update Controller

This block belongs to one timer channel in a group of six channels. It decides when the values written into a small bank of preload (shadow) registers are copied into the active registers that the channel uses. The copy is started by a set of trigger sources, and each source has its own enable bit. The sources are the update events of the sibling channels, this channel's counter reset or wrap, and the expiry of the repetition count. The block drives a one-cycle transfer strobe. In the same cycle that the strobe is high, the active registers show the transferred values.

The position of this channel within the group is set by a parameter. The sibling enable that would point at this channel itself is forced off. A configuration port loads the enable bits. A separate write port loads the shadow registers.

Top module: `shx_update_ctrl`

## Requirements
- R1: After a reset with `rst_n` low, `xfer_o` is 0, every active register is 0 and every enable bit is cleared. A sibling pulse, a counter reset or a wrap then produces no transfer until the enables are written.
- R2: Bit i of `cfg_sib_en` enables sibling channel i, where 1 means enabled and 0 means disabled. A pulse on `sib_upd[i]` with the enable set raises `xfer_o` on the next cycle. With the enable clear, the pulse gives no transfer.
- R3: The sibling enable at index `SELF_IDX` (default 2) has no effect. A pulse on `sib_upd[SELF_IDX]` never causes a transfer, whatever value was written to that bit.
- R4: When `cfg_rst_en`=1 has been stored, a pulse on `cnt_reset` or on `cnt_wrap` raises `xfer_o` on the next cycle.
- R5: When `cfg_rep_en`=1 has been stored, a `cnt_wrap` pulse while `rep_count` equals 0 raises `xfer_o` on the next cycle. With a nonzero count, this source gives no transfer.
- R6: Any number of enabled triggers in one cycle produce a strobe that lasts exactly one cycle.
- R7: A write to address a (0 to `N_REG`-1) changes only shadow register a. Active registers keep their value in every cycle without a strobe. Writes to addresses at or above `N_REG` are ignored.
- R8: If a shadow write and a trigger occur in the same cycle, the value being written is the one transferred.
- R9: Active register i appears on `active_o[i*DATA_W +: DATA_W]`. It holds the transferred shadow value from the cycle in which `xfer_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sib_upd | input | N_CH | Update pulses of the channels in the group, one bit per channel |
| cnt_reset | input | 1 | Local counter reset pulse |
| cnt_wrap | input | 1 | Local counter wrapped to 0 after reaching its period |
| rep_count | input | REP_W | Current repetition count |
| cfg_we | input | 1 | Load the enable bits |
| cfg_sib_en | input | N_CH | Sibling trigger enables |
| cfg_rst_en | input | 1 | Reset and wrap trigger enable |
| cfg_rep_en | input | 1 | Repetition expiry trigger enable |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | ADDR_W | Shadow register index |
| wr_data | input | DATA_W | Shadow write data |
| xfer_o | output | 1 | Transfer strobe |
| active_o | output | N_REG*DATA_W | Active register values, flattened |

## Verification
The hardest cases to reach are those where several things coincide. One is a shadow write landing in the same cycle as a trigger. Another is several sources firing together with the stored self enable bit set. Reaching these needs specific cross timing, not single events. The bench walks all 64 sibling enable patterns and, for each pattern, pulses every channel. It writes a fresh shadow value with every enable load, so each transfer moves distinct data. It also sweeps every combination of the reset and repetition enables, every small repetition count and every counter event. Finally, it forces the all-sources-at-once and write-during-trigger cycles on purpose.

// File: rtl/shx_pkg.sv
// Shared types for the shadow update controller.
// Assumes: nothing beyond standard SystemVerilog.
package shx_pkg;

    // One flag per kind of trigger source that asked for a transfer.
    typedef struct packed {
        logic sib;
        logic rst;
        logic rep;
    } trig_src_t;

endpackage

// File: rtl/shx_enable_reg.sv
// Holds the trigger enable bits of this channel.
// Assumes: the self-referencing sibling bit is forced to zero on load.
module shx_enable_reg #(
    parameter int N_CH     = 6,
    parameter int SELF_IDX = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [N_CH-1:0] cfg_sib_en,
    input  logic            cfg_rst_en,
    input  logic            cfg_rep_en,
    output logic [N_CH-1:0] sib_en_q,
    output logic            rst_en_q,
    output logic            rep_en_q
);
    localparam logic [N_CH-1:0] SELF_MASK = N_CH'(1) << SELF_IDX;

    // Load or clear the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sib_en_q <= '0;
            rst_en_q <= 1'b0;
            rep_en_q <= 1'b0;
        end else if (cfg_we) begin
            sib_en_q <= cfg_sib_en & ~SELF_MASK;
            rst_en_q <= cfg_rst_en;
            rep_en_q <= cfg_rep_en;
        end
    end

    // R1: the cycle after a reset all enables are clear
    a_r1_enables_cleared: assert property (@(posedge clk)
        !rst_n |=> (sib_en_q == '0 && !rst_en_q && !rep_en_q));

endmodule

// File: rtl/shx_trig_merge.sv
// Combines all enabled trigger sources into one transfer request.
// Assumes: inputs are single-cycle pulses; enables are already registered.
module shx_trig_merge
    import shx_pkg::*;
#(
    parameter int N_CH     = 6,
    parameter int SELF_IDX = 2,
    parameter int REP_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  sib_upd,
    input  logic             cnt_reset,
    input  logic             cnt_wrap,
    input  logic [REP_W-1:0] rep_count,
    input  logic [N_CH-1:0]  sib_en,
    input  logic             rst_en,
    input  logic             rep_en,
    output trig_src_t        src,
    output logic             fire
);
    logic [N_CH-1:0] hit;

    // Per-channel sibling hit; the own channel is never a source.
    for (genvar i = 0; i < N_CH; i++) begin : g_hit
        if (i == SELF_IDX) begin : g_self
            assign hit[i] = 1'b0 & sib_upd[i] & sib_en[i];
        end else begin : g_other
            assign hit[i] = sib_upd[i] & sib_en[i];
        end
    end

    // Gather the three source kinds and merge them.
    always_comb begin
        src.sib = |hit;
        src.rst = rst_en & (cnt_reset | cnt_wrap);
        src.rep = rep_en & cnt_wrap & (rep_count == '0);
        fire    = src.sib | src.rst | src.rep;
    end

    // R3: a pulse from the own channel alone never requests a transfer
    a_r3_self_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sib_upd == (N_CH'(1) << SELF_IDX) && !cnt_reset && !cnt_wrap) |-> !fire);

    // R5: a wrap with nonzero count and no other source does not fire
    a_r5_rep_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (sib_upd == '0 && !rst_en && cnt_wrap && rep_count != '0) |-> !fire);

endmodule

// File: rtl/shx_shadow_bank.sv
// Shadow and active register bank with same-cycle write forwarding.
// Assumes: load is a single-cycle request; out-of-range addresses are dropped.
module shx_shadow_bank #(
    parameter int N_REG  = 3,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    load,
    output logic [N_REG*DATA_W-1:0] active_flat
);
    logic [DATA_W-1:0] shadow_q   [N_REG];
    logic [DATA_W-1:0] shadow_nxt [N_REG];
    logic [DATA_W-1:0] active_q   [N_REG];
    logic [N_REG-1:0]  wr_hit;

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        // Decode the write and forward it into the transfer path.
        always_comb begin
            wr_hit[i]     = wr_en && (wr_addr == ADDR_W'(i));
            shadow_nxt[i] = wr_hit[i] ? wr_data : shadow_q[i];
        end

        // Keep the shadow copy.
        always_ff @(posedge clk) begin
            if (!rst_n) shadow_q[i] <= '0;
            else        shadow_q[i] <= shadow_nxt[i];
        end

        // Copy shadow to active on a transfer.
        always_ff @(posedge clk) begin
            if (!rst_n)    active_q[i] <= '0;
            else if (load) active_q[i] <= shadow_nxt[i];
        end

        assign active_flat[i*DATA_W +: DATA_W] = active_q[i];

        // R7: without a transfer the active copy holds
        a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(active_q[i]));

        // R8: a write in the transfer cycle is what lands in the active copy
        a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (load && wr_hit[i]) |=> (active_q[i] == $past(wr_data)));
    end

endmodule

// File: rtl/shx_update_ctrl.sv
// Top: decides when shadow values of one timer channel become active.
// Assumes: all event inputs are synchronous single-cycle pulses.
module shx_update_ctrl
    import shx_pkg::*;
#(
    parameter int N_CH     = 6,
    parameter int SELF_IDX = 2,
    parameter int N_REG    = 3,
    parameter int DATA_W   = 16,
    parameter int REP_W    = 8,
    localparam int ADDR_W  = (N_REG > 1) ? $clog2(N_REG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         sib_upd,
    input  logic                    cnt_reset,
    input  logic                    cnt_wrap,
    input  logic [REP_W-1:0]        rep_count,
    input  logic                    cfg_we,
    input  logic [N_CH-1:0]         cfg_sib_en,
    input  logic                    cfg_rst_en,
    input  logic                    cfg_rep_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    xfer_o,
    output logic [N_REG*DATA_W-1:0] active_o
);
    logic [N_CH-1:0] sib_en_q;
    logic            rst_en_q;
    logic            rep_en_q;
    trig_src_t       src;
    logic            fire;
    logic            xfer_q;

    shx_enable_reg #(.N_CH(N_CH), .SELF_IDX(SELF_IDX)) u_en (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sib_en(cfg_sib_en),
        .cfg_rst_en(cfg_rst_en), .cfg_rep_en(cfg_rep_en),
        .sib_en_q(sib_en_q), .rst_en_q(rst_en_q), .rep_en_q(rep_en_q)
    );

    shx_trig_merge #(.N_CH(N_CH), .SELF_IDX(SELF_IDX), .REP_W(REP_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .sib_upd(sib_upd), .cnt_reset(cnt_reset),
        .cnt_wrap(cnt_wrap), .rep_count(rep_count), .sib_en(sib_en_q),
        .rst_en(rst_en_q), .rep_en(rep_en_q), .src(src), .fire(fire)
    );

    shx_shadow_bank #(.N_REG(N_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(fire), .active_flat(active_o)
    );

    // Register the strobe so it lines up with the active update.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_q <= 1'b0;
        else        xfer_q <= fire;
    end

    assign xfer_o = xfer_q;

    // R1: reset leaves no strobe and zeroed active registers
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!xfer_o && active_o == '0));

    // R4: counter reset with its enable stored gives a strobe
    a_r4_reset_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_en_q && cnt_reset) |=> xfer_o);

    // R5: wrap at zero repetition count with its enable stored gives a strobe
    a_r5_rep_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_en_q && cnt_wrap && rep_count == '0) |=> xfer_o);

    // R6: a lone triggering cycle gives a strobe of one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && !fire) |=> !xfer_o);

endmodule

// File: tb/sim_shx_update_ctrl.sv
module sim_shx_update_ctrl;
    localparam int N_CH = 6, SELF = 2, N_REG = 3, DW = 16, RW = 8, AW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_CH-1:0] sib_upd = '0;
    logic cnt_reset = 0, cnt_wrap = 0;
    logic [RW-1:0] rep_count = '0;
    logic cfg_we = 0, cfg_rst_en = 0, cfg_rep_en = 0;
    logic [N_CH-1:0] cfg_sib_en = '0;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic xfer_o;
    logic [N_REG*DW-1:0] active_o;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [N_CH-1:0] m_sib = '0;
    logic m_rst = 0, m_rep = 0;
    logic [DW-1:0] m_sh [N_REG];
    logic [DW-1:0] m_act[N_REG];

    always #2.5 clk = ~clk;

    shx_update_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sib_upd(sib_upd), .cnt_reset(cnt_reset),
        .cnt_wrap(cnt_wrap), .rep_count(rep_count), .cfg_we(cfg_we),
        .cfg_sib_en(cfg_sib_en), .cfg_rst_en(cfg_rst_en), .cfg_rep_en(cfg_rep_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .xfer_o(xfer_o), .active_o(active_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_fire();
        logic f = 1'b0;
        for (int i = 0; i < N_CH; i++)
            if (i != SELF && m_sib[i] && sib_upd[i]) f = 1'b1;   // R2, R3
        if (m_rst && (cnt_reset || cnt_wrap)) f = 1'b1;           // R4
        if (m_rep && cnt_wrap && rep_count == '0) f = 1'b1;       // R5
        return f;
    endfunction

    // One clock with the inputs currently driven; then check the outputs.
    task automatic tick(input string req);
        logic f;
        f = rst_n ? exp_fire() : 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) begin
            m_sib = '0; m_rst = 0; m_rep = 0;
            for (int i = 0; i < N_REG; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        end else begin
            if (wr_en && wr_addr < N_REG) m_sh[wr_addr] = wr_data;   // R7
            if (f) for (int i = 0; i < N_REG; i++) m_act[i] = m_sh[i]; // R8
            if (cfg_we) begin m_sib = cfg_sib_en; m_rst = cfg_rst_en; m_rep = cfg_rep_en; end
        end
        check({req, " xfer"}, DW'(xfer_o), DW'(f));
        for (int i = 0; i < N_REG; i++)
            check({req, " active(R9)"}, active_o[i*DW +: DW], m_act[i]);
        sib_upd = '0; cnt_reset = 0; cnt_wrap = 0; cfg_we = 0; wr_en = 0;
    endtask

    initial begin
        for (int i = 0; i < N_REG; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        @(negedge clk);
        // R1: reset state
        tick("R1"); tick("R1");
        rst_n = 1;
        sib_upd = '1; cnt_reset = 1; cnt_wrap = 1; tick("R1");
        tick("R1");

        // R2 / R3: every sibling enable pattern against every channel pulse
        for (int cfg = 0; cfg < 64; cfg++) begin
            cfg_we = 1; cfg_sib_en = N_CH'(cfg);
            wr_en = 1; wr_addr = AW'(cfg % N_REG); wr_data = DW'(cfg * 37 + 5);
            tick("R7");
            for (int ch = 0; ch < N_CH; ch++) begin
                sib_upd = N_CH'(1) << ch;
                tick(ch == SELF ? "R3" : "R2");
                tick("R6");
            end
        end

        // R4 / R5: reset and repetition sources
        for (int en = 0; en < 4; en++)
            for (int rc = 0; rc < 4; rc++)
                for (int ev = 0; ev < 3; ev++) begin
                    cfg_we = 1; cfg_sib_en = '0; cfg_rst_en = en[0]; cfg_rep_en = en[1];
                    wr_en = 1; wr_addr = AW'(ev); wr_data = DW'(en * 100 + rc * 10 + ev);
                    tick("R7");
                    rep_count = RW'(rc);
                    cnt_reset = (ev != 1); cnt_wrap = (ev != 0);
                    tick(en[1] ? "R5" : "R4");
                end
        rep_count = '0;

        // R6: everything at once including the self bit
        cfg_we = 1; cfg_sib_en = '1; cfg_rst_en = 1; cfg_rep_en = 1; tick("R6");
        sib_upd = '1; cnt_reset = 1; cnt_wrap = 1; tick("R6");
        tick("R6");

        // R8: write in the trigger cycle
        for (int a = 0; a < N_REG; a++) begin
            wr_en = 1; wr_addr = AW'(a); wr_data = DW'(16'hA50 + a);
            sib_upd = 6'b000001; tick("R8");
        end

        // R7: writes without a trigger, including an out-of-range address
        for (int a = 0; a < 4; a++) begin
            wr_en = 1; wr_addr = AW'(a); wr_data = DW'(16'h7E00 + a); tick("R7");
        end
        cnt_reset = 1; tick("R7");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule